// File: doc/BRIEF.md
# Multiplexed-Bus Cycle Generator

This block is a bus master for a narrow external bus where the low address byte and the data byte take turns on one shared port. It runs from a fast reference clock and divides it into a slower bus clock E. Every bus cycle lasts one E period. The high address byte sits on its own port for the whole cycle. In the first half of the cycle, while E is low, the shared port carries the low address byte. A single-clock address strobe marks the point where an external latch must capture it. In the second half, while E is high, the same port carries data in the direction chosen by the read/write line.

A request port supplies an address, write data and a direction. The block takes a request only at the boundary between bus cycles. Read data comes back with a one-clock done pulse. When no request is waiting, the block runs idle cycles with the bus released. Two mode inputs decide whether bus cycles run at all. An asynchronous reset is released through an on-block synchronizer.

Top module: `mxb_bus_master`

## Requirements
- R1: While rst_n is low, every output is in its idle state: bus_e, bus_as, bus_ad_oe, req_ready and rd_valid are 0, bus_rw is 1, and bus_addr_hi, bus_ad_out and rd_data are 0.
- R2: While cycles run, each cycle lasts DIV reference clocks, counted as phases 0 to DIV-1. bus_e is 0 in the first DIV/2 phases and 1 in the rest.
- R3: bus_as is 1 only in phase DIV/2-1, the last E-low clock. It therefore falls exactly when bus_e rises.
- R4: For the whole cycle, bus_addr_hi carries address bits [15:8] of the request. In the E-low phases of a request cycle, bus_ad_out carries bits [7:0] and bus_ad_oe is 1.
- R5: bus_rw is 0 for every phase of a write cycle and 1 in every other cycle.
- R6: In the E-high phases of a write cycle, bus_ad_oe is 1 and bus_ad_out carries the write data.
- R7: In the E-high phases of a read cycle, bus_ad_oe is 0, so the port is released starting from the first E-high clock. bus_ad_in is sampled on the clock edge that ends phase DIV-1, which is the falling edge of E. rd_valid is 1 for exactly the following clock, and rd_data holds the sampled byte until the next read.
- R8: req_ready is 1 only in phase DIV-1 of a running cycle, or on any clock while cycles are stopped. A request with req_valid=1 is taken on a clock edge where req_ready=1, and its cycle starts at phase 0 on the next clock.
- R9: A cycle that starts with no request is an idle cycle. E and the strobe still toggle, bus_rw is 1, bus_ad_oe is 0, and bus_addr_hi and bus_ad_out are 0.
- R10: Cycles run only when mode_b=1 and mode_a=1. Any other code stops the bus at the next cycle boundary: a cycle in progress completes. While stopped, bus_e and bus_as stay 0, bus_rw stays 1, the port is released and requests wait. req_ready is 0 whenever the mode is not (1,1).
- R11: After rst_n rises, req_ready stays 0 for the first SYNC_STAGES clock edges. It can first be 1 after the second edge when SYNC_STAGES=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_a | input | 1 | Mode select bit A |
| mode_b | input | 1 | Mode select bit B |
| req_valid | input | 1 | A request is offered |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request taken on this edge if req_valid |
| rd_valid | output | 1 | One-clock read done pulse |
| rd_data | output | DATA_W | Last read byte |
| bus_e | output | 1 | Bus clock E |
| bus_as | output | 1 | Address strobe |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_addr_hi | output | ADDR_W-DATA_W | High address byte |
| bus_ad_out | output | DATA_W | Shared port, driven value |
| bus_ad_oe | output | 1 | Shared port drive enable |
| bus_ad_in | input | DATA_W | Shared port, received value |

## Verification
A request that sits on the port before a clock edge where req_ready is 1 shows its pins from the clock after that edge. From there the pins follow a fixed phase schedule: the low address for DIV/2 clocks, the strobe in the last of those clocks, then data for DIV/2 clocks. Read data is sampled on the edge that ends the cycle, and rd_valid and rd_data appear in the clock after it. The bench's behavioural model steps on each rising edge with the inputs as they stood before that edge. All outputs are compared with the model at the falling edge that follows, so every result is checked in the exact clock the schedule puts it in. A model of the external device latches the address on the strobe and serves and stores data over the bus. This checks the write and read paths end to end through the shared port.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

  typedef enum logic [1:0] {
    XK_IDLE  = 2'd0,
    XK_READ  = 2'd1,
    XK_WRITE = 2'd2
  } xfer_kind_e;

  // Bus cycles run only in the expanded code (mode_b, mode_a) = (1, 1).
  function automatic logic mode_runs(input logic mb, input logic ma);
    return mb & ma;
  endfunction

endpackage

// File: rtl/mxb_rst_sync.sv
module mxb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/mxb_phase_gen.sv
module mxb_phase_gen #(
  parameter int DIV  = 4,
  parameter int PH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_en,
  output logic            run_q,
  output logic [PH_W-1:0] ph_q,
  output logic            at_bound,
  output logic            go,
  output logic            last_clk
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

  logic            run_d;
  logic [PH_W-1:0] ph_d;

  assign last_clk = run_q && (ph_q == PH_LAST);
  assign at_bound = !run_q || last_clk;
  assign go       = at_bound && run_en;

  always_comb begin
    run_d = run_q;
    ph_d  = ph_q;
    if (go) begin
      run_d = 1'b1;
      ph_d  = '0;
    end else if (at_bound) begin
      run_d = 1'b0;
      ph_d  = '0;
    end else begin
      ph_d  = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ph_q  <= '0;
    end else begin
      run_q <= run_d;
      ph_q  <= ph_d;
    end
  end
endmodule

// File: rtl/mxb_xfer_reg.sv
module mxb_xfer_reg
  import mxb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              at_bound,
  input  logic              go,
  input  logic              last_clk,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_ad_in,
  output xfer_kind_e        kind_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              rd_valid_q,
  output logic [DATA_W-1:0] rd_data_q
);
  xfer_kind_e        kind_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;
  logic              rd_valid_d;
  logic [DATA_W-1:0] rd_data_d;
  logic              load_en;
  logic              cap_en;

  assign load_en = at_bound;
  assign cap_en  = last_clk && (kind_q == XK_READ);

  always_comb begin
    kind_d  = kind_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (load_en) begin
      if (go && req_valid) begin
        kind_d  = req_we ? XK_WRITE : XK_READ;
        addr_d  = req_addr;
        wdata_d = req_we ? req_wdata : '0;
      end else begin
        kind_d  = XK_IDLE;
        addr_d  = '0;
        wdata_d = '0;
      end
    end
    rd_valid_d = cap_en;
    rd_data_d  = cap_en ? bus_ad_in : rd_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q     <= XK_IDLE;
      addr_q     <= '0;
      wdata_q    <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      kind_q     <= kind_d;
      addr_q     <= addr_d;
      wdata_q    <= wdata_d;
      rd_valid_q <= rd_valid_d;
      rd_data_q  <= rd_data_d;
    end
  end
endmodule

// File: rtl/mxb_pin_mux.sv
module mxb_pin_mux
  import mxb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DIV    = 4,
  parameter int PH_W   = 2
) (
  input  logic                     run_q,
  input  logic [PH_W-1:0]          ph_q,
  input  xfer_kind_e               kind_q,
  input  logic [ADDR_W-1:0]        addr_q,
  input  logic [DATA_W-1:0]        wdata_q,
  output logic                     bus_e,
  output logic                     bus_as,
  output logic                     bus_rw,
  output logic [ADDR_W-DATA_W-1:0] bus_addr_hi,
  output logic [DATA_W-1:0]        bus_ad_out,
  output logic                     bus_ad_oe
);
  localparam int              HALF    = DIV / 2;
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);
  localparam logic [PH_W-1:0] PH_AS   = PH_W'(HALF - 1);

  logic addr_phase;
  logic is_write;
  logic is_busy;

  assign addr_phase = ph_q < PH_HALF;
  assign is_write   = run_q && (kind_q == XK_WRITE);
  assign is_busy    = run_q && (kind_q != XK_IDLE);

  always_comb begin
    bus_e       = run_q && !addr_phase;
    bus_as      = run_q && (ph_q == PH_AS);
    bus_rw      = !is_write;
    bus_addr_hi = run_q ? addr_q[ADDR_W-1:DATA_W] : '0;
    bus_ad_oe   = is_busy && (addr_phase || is_write);
    bus_ad_out  = '0;
    if (bus_ad_oe) begin
      bus_ad_out = addr_phase ? addr_q[DATA_W-1:0] : wdata_q;
    end
  end
endmodule

// File: rtl/mxb_bus_master.sv
module mxb_bus_master
  import mxb_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int DIV         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_a,
  input  logic                     mode_b,
  input  logic                     req_valid,
  input  logic                     req_we,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     req_ready,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     bus_e,
  output logic                     bus_as,
  output logic                     bus_rw,
  output logic [ADDR_W-DATA_W-1:0] bus_addr_hi,
  output logic [DATA_W-1:0]        bus_ad_out,
  output logic                     bus_ad_oe,
  input  logic [DATA_W-1:0]        bus_ad_in
);
  localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;

  logic              srst_n;
  logic              run_en;
  logic              run_q;
  logic [PH_W-1:0]   ph_q;
  logic              at_bound;
  logic              go;
  logic              last_clk;
  xfer_kind_e        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign run_en    = srst_n && mode_runs(mode_b, mode_a);
  assign req_ready = go;

  mxb_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  mxb_phase_gen #(.DIV(DIV), .PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .run_q(run_q), .ph_q(ph_q),
    .at_bound(at_bound), .go(go), .last_clk(last_clk)
  );

  mxb_xfer_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .at_bound(at_bound), .go(go), .last_clk(last_clk),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .bus_ad_in(bus_ad_in), .kind_q(kind_q),
    .addr_q(addr_q), .wdata_q(wdata_q), .rd_valid_q(rd_valid), .rd_data_q(rd_data)
  );

  mxb_pin_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV(DIV), .PH_W(PH_W)) u_pins (
    .run_q(run_q), .ph_q(ph_q), .kind_q(kind_q), .addr_q(addr_q), .wdata_q(wdata_q),
    .bus_e(bus_e), .bus_as(bus_as), .bus_rw(bus_rw), .bus_addr_hi(bus_addr_hi),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe)
  );
endmodule

// File: rtl/mxb_bus_chk.sv
module mxb_bus_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_a,
  input logic mode_b,
  input logic req_ready,
  input logic rd_valid,
  input logic bus_e,
  input logic bus_as,
  input logic bus_rw,
  input logic bus_ad_oe,
  input logic [7:0] bus_addr_hi
);
  // R3: E only rises right after a strobe clock
  p_e_rise_after_as_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_e) |-> $past(bus_as));
  // R3: strobe is one clock wide
  p_as_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as |=> !bus_as);
  // R4: high address holds while E is high
  p_hi_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_e |-> $stable(bus_addr_hi));
  // R5: direction holds while E is high
  p_rw_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_e |-> $stable(bus_rw));
  // R7: port released during read data phase
  p_read_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_e && bus_rw) |-> !bus_ad_oe);
  // R7: done is a single pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  // R7: done follows an E-high clock
  p_done_after_efall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_e));
  // R8: a ready during E high is the cycle's last clock
  p_ready_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && bus_e) |=> !bus_e);
  // R10: ready only in expanded mode
  p_ready_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mode_a && mode_b));
endmodule

bind mxb_bus_master mxb_bus_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
  .req_ready(req_ready), .rd_valid(rd_valid), .bus_e(bus_e), .bus_as(bus_as),
  .bus_rw(bus_rw), .bus_ad_oe(bus_ad_oe), .bus_addr_hi(bus_addr_hi[7:0])
);

// File: tb/sim_mxb_bus_master.sv
`timescale 1ns/1ps
module sim_mxb_bus_master;
  localparam int CLK_PERIOD = 125;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic clk, rst_n, mode_a, mode_b, req_valid, req_we;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata, rd_data, bus_ad_out, bus_ad_in, bus_addr_hi;
  logic req_ready, rd_valid, bus_e, bus_as, bus_rw, bus_ad_oe;

  mxb_bus_master u0 (
    .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .bus_e(bus_e), .bus_as(bus_as), .bus_rw(bus_rw),
    .bus_addr_hi(bus_addr_hi), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
    .bus_ad_in(bus_ad_in)
  );

  initial begin
    clk = 0;
    forever #(CLK_PERIOD / 2.0) clk = ~clk;
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct { bit we; logic [15:0] a; logic [7:0] d; } rq_t;
  rq_t rq_q[$];

  // reference model state
  bit m_run, m_s1, m_s2, m_acc, m_rdv;
  int m_ph, m_kind;            // kind: 0 idle, 1 read, 2 write
  logic [15:0] m_addr;
  logic [7:0]  m_wd, m_rdd;
  logic [7:0]  m_mem [int];
  // external device model
  logic [7:0]  dev_mem [int];
  logic [7:0]  dev_lat;

  function automatic logic [7:0] init_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] m_look(input logic [15:0] a);
    return m_mem.exists(int'(a)) ? m_mem[int'(a)] : init_val(a);
  endfunction
  function automatic logic [7:0] d_look(input logic [15:0] a);
    return dev_mem.exists(int'(a)) ? dev_mem[int'(a)] : init_val(a);
  endfunction

  task automatic model_reset();
    m_run = 0; m_s1 = 0; m_s2 = 0; m_acc = 0; m_rdv = 0;
    m_ph = 0; m_kind = 0; m_addr = 0; m_wd = 0; m_rdd = 0;
    rq_q.delete();
  endtask

  task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // model step on each rising edge, using inputs as they stood before it
  always @(posedge clk) begin
    if (rst_n) begin
      bit rdy;
      rdy = m_s2 && mode_b && mode_a && (!m_run || m_ph == DIV - 1);
      m_acc = rdy && req_valid;
      if (m_run && m_ph == DIV - 1 && m_kind == 1) begin
        m_rdv = 1; m_rdd = m_look(m_addr);
      end else m_rdv = 0;
      if (rdy) begin
        m_run = 1; m_ph = 0;
        if (req_valid) begin
          m_kind = req_we ? 2 : 1; m_addr = req_addr; m_wd = req_we ? req_wdata : 8'h00;
          if (req_we) m_mem[int'(req_addr)] = req_wdata;
        end else begin
          m_kind = 0; m_addr = 0; m_wd = 0;
        end
      end else if (!m_run || m_ph == DIV - 1) begin
        m_run = 0; m_ph = 0; m_kind = 0; m_addr = 0; m_wd = 0;
      end else m_ph++;
      m_s2 = m_s1; m_s1 = 1;
    end
  end

  task automatic compare_all();
    bit ab, mode_on;
    bit e_x, as_x, oe_x;
    logic [7:0] out_x;
    string t_e, t_as, t_hi, t_rw, t_oe, t_rdy, t_rd;
    mode_on = mode_a && mode_b;
    ab   = m_ph < HALF;
    e_x  = m_run && !ab;
    as_x = m_run && (m_ph == HALF - 1);
    oe_x = m_run && m_kind != 0 && (ab || m_kind == 2);
    out_x = !oe_x ? 8'h00 : (ab ? m_addr[7:0] : m_wd);
    t_e = m_run ? "R2" : "R10"; t_as = m_run ? "R3" : "R10"; t_hi = "R4";
    t_rw = (m_run && m_kind == 0) ? "R9" : (m_run ? "R5" : "R10");
    if (!m_run) t_oe = "R10";
    else if (m_kind == 0) t_oe = "R9";
    else if (ab) t_oe = "R4";
    else if (m_kind == 2) t_oe = "R6";
    else t_oe = "R7";
    t_rdy = !m_s2 ? "R11" : (mode_on ? "R8" : "R10");
    t_rd = "R7";
    if (!rst_n) begin
      t_e = "R1"; t_as = "R1"; t_hi = "R1"; t_rw = "R1"; t_oe = "R1"; t_rdy = "R1"; t_rd = "R1";
    end
    chk(t_e,   "bus_e",       bus_e,       e_x);
    chk(t_as,  "bus_as",      bus_as,      as_x);
    chk(t_hi,  "bus_addr_hi", bus_addr_hi, m_addr[15:8]);
    chk(t_rw,  "bus_rw",      bus_rw,      !(m_run && m_kind == 2));
    chk(t_oe,  "bus_ad_oe",   bus_ad_oe,   oe_x);
    chk(t_oe,  "bus_ad_out",  bus_ad_out,  out_x);
    chk(t_rdy, "req_ready",   req_ready,   m_s2 && mode_on && (!m_run || m_ph == DIV - 1));
    chk(t_rd,  "rd_valid",    rd_valid,    m_rdv);
    chk(t_rd,  "rd_data",     rd_data,     m_rdd);
  endtask

  // compare, device and request driver on each falling edge
  always @(negedge clk) begin
    if (!finished) begin
      compare_all();
      if (bus_as) dev_lat = bus_ad_out;
      if (bus_e && !bus_rw && bus_ad_oe) dev_mem[int'({bus_addr_hi, dev_lat})] = bus_ad_out;
      if (m_acc) begin
        if (rq_q.size() != 0) void'(rq_q.pop_front());
        m_acc = 0;
      end
      if (rq_q.size() != 0) begin
        req_valid = 1; req_we = rq_q[0].we; req_addr = rq_q[0].a; req_wdata = rq_q[0].d;
      end else begin
        req_valid = 0; req_we = 0; req_addr = 16'h0; req_wdata = 8'h0;
      end
      bus_ad_in = (bus_e && bus_rw) ? d_look({bus_addr_hi, dev_lat}) : 8'h00;
    end
  end

  task automatic push(input bit we, input logic [15:0] a, input logic [7:0] d);
    rq_t r;
    r.we = we; r.a = a; r.d = d;
    rq_q.push_back(r);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic drain();
    while (rq_q.size() != 0) @(negedge clk);
    step(8);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; mode_a = 0; mode_b = 0; req_valid = 0; req_we = 0;
    req_addr = 0; req_wdata = 0; bus_ad_in = 0; dev_lat = 0;
    model_reset();
    step(3);                                // R1 checked during reset
    rst_n = 1; mode_b = 1; mode_a = 1;      // R11 sync delay, then R9 idle cycles
    step(12);
    // R4 R5 R6 R7: writes and reads, back to back
    push(1, 16'h4000, 8'hA5);
    push(0, 16'h4000, 8'h00);
    push(0, 16'h1234, 8'h00);
    push(1, 16'hFFFF, 8'h3C);
    push(0, 16'hFFFF, 8'h00);
    push(1, 16'h0000, 8'hC3);
    push(0, 16'h0000, 8'h00);
    push(0, 16'h00FF, 8'h00);
    drain();
    // R8: requests arriving at odd phases wait for a boundary
    step(1); push(0, 16'h4000, 8'h00); step(2); push(1, 16'h8081, 8'h7E);
    step(3); push(0, 16'h8081, 8'h00);
    drain();
    // R10: leave expanded mode mid-cycle with a request pending
    push(1, 16'h2222, 8'h11); push(0, 16'h2222, 8'h00);
    step(2); mode_a = 0;                    // (1,0): single-chip
    step(14); push(0, 16'h5555, 8'h00);
    step(6); mode_a = 1;
    drain();
    mode_b = 0; mode_a = 1; push(1, 16'h3333, 8'h99); step(10);   // R10 code (0,1)
    mode_a = 0; step(6);                                          // R10 code (0,0)
    mode_b = 1; mode_a = 1;
    push(0, 16'h3333, 8'h00);
    drain();
    // R1: asynchronous reset in the middle of a cycle
    push(0, 16'h4000, 8'h00);
    step(5);
    rst_n = 0; model_reset();
    step(3);
    rst_n = 1;
    step(3);
    push(0, 16'h4000, 8'h00); push(0, 16'hFFFF, 8'h00);
    drain();
    finished = 1;
    summary();
    $finish;
  end
endmodule